// File: doc/BRIEF.md
# Matched-Filter Template Multiplier with Power Plane Writer

This block is the frequency-domain stage of a matched-filter bank used in an acceleration search over complex spectra. Each spectrum segment arrives already transformed to the frequency domain. The block multiplies every sample by a group of stored complex templates. Each template drives two filters at once: a positive-acceleration filter uses the template as stored, and the matching negative-acceleration filter uses its complex conjugate. The products leave through a streaming port toward an external inverse transform.

The inverse-transformed samples come back through a second streaming port. The block discards the overlap region of each block, reduces each remaining complex sample to a rounded and saturated power value, and writes it into a two-dimensional filter-output plane. The plane is stored column by column, so all filter rows of one frequency bin sit at adjacent addresses. The zero-acceleration filter occupies the middle row.

The filter bank is covered in a fixed number of passes. Each pass first loads one template word for every sample index and then runs the multiply and write-back paths concurrently. A done pulse follows the last pass of a segment. The segment counter then advances and later wraps.

Top module: `accel_tmul_pdet`

## Requirements
- R1: After reset, the block is in the template-load phase. tpl_ready is 1, and spec_ready, ret_ready, prod_valid, wr_valid and done are all 0.
- R2: A pass accepts exactly NPT template words. The template word for sample index i holds lane l as real part at bits [2l·TW +: TW] and imaginary part at bits [(2l+1)·TW +: TW]. tpl_ready then stays 0 until the pass completes, and tpl_ready and spec_ready are never 1 together.
- R3: Product slot 2l is x·h, computed at full precision (DW+TW+1 bits, signed), where x is the spectrum sample and h is the lane-l template for the same sample index. Slot j carries its real part at bits [2j·PRW +: PRW] and its imaginary part at bits [(2j+1)·PRW +: PRW].
- R4: Product slot 2l+1 is x·conj(h). Its real part is ac+bd and its imaginary part is bc−ad, where x = a+jb and h = c+jd.
- R5: Exactly NPT spectrum samples are accepted per pass, after which spec_ready stays 0. A product that is held while prod_ready is 0 keeps prod_valid asserted and its data unchanged.
- R6: In each returned block, the first OVL samples (index k < OVL) cause no plane write. A block therefore yields (NPT−OVL)·(2·NTPL−1) writes per segment over all passes.
- R7: The written value is (re²+im²+2^(PSH−1)) >> PSH, saturated to 2^PW−1.
- R8: Lane l in pass p serves template t = p·LANES+l. Its positive slot writes row MID+t and its negative slot writes row MID−t, where MID = NTPL−1. Template 0 writes only its positive slot, and templates with t ≥ NTPL write nothing.
- R9: The write address is bin·(2·NTPL−1)+row, where bin = seg·(NPT−OVL)+k−OVL. Writes for one returned word are issued in ascending slot order.
- R10: After the final write of the last pass, done pulses for exactly one cycle. The segment index then advances and wraps to 0 after SEGS segments.
- R11: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr and wr_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpl_valid | input | 1 | Template word valid |
| tpl_ready | output | 1 | Template word accepted (load phase) |
| tpl_data | input | LANES·2·TW | One complex template value per lane |
| spec_valid | input | 1 | Spectrum sample valid |
| spec_ready | output | 1 | Spectrum sample accepted |
| spec_re | input | DW | Spectrum real part, signed |
| spec_im | input | DW | Spectrum imaginary part, signed |
| prod_valid | output | 1 | Product word valid toward inverse transform |
| prod_ready | input | 1 | Product word taken |
| prod_data | output | LANES·4·PRW | Positive and conjugate products per lane |
| ret_valid | input | 1 | Inverse-transformed word valid |
| ret_ready | output | 1 | Returned word accepted |
| ret_data | input | LANES·4·RW | Returned complex samples, same slot layout as products |
| wr_valid | output | 1 | Plane write valid |
| wr_ready | input | 1 | Plane write taken |
| wr_addr | output | AW | Column-ordered plane address |
| wr_data | output | PW | Power value |
| done | output | 1 | One-cycle pulse after the last pass of a segment |

## Verification
The multiply path and the write-back path run at the same time within a pass. A product handoff and a plane write can therefore happen on the same clock edge, and so can the last product of a pass and a write still pending from an earlier returned word. The bench causes this by driving returned words while spectrum samples are still streaming in. It throttles prod_ready and wr_ready on different cadences so that stalls on one side overlap with progress on the other. Every product is compared against complex arithmetic computed in the bench, and every write is compared against an ordered list of expected address and power pairs. The bench also checks that done arrives only after that list has been emptied.

// File: rtl/accel_tmul_pkg.sv
package accel_tmul_pkg;

  typedef enum logic {PH_LOAD, PH_RUN} tmul_phase_e;

  // Real part from shared partial products; conj selects the conjugated template.
  function automatic logic signed [63:0] mix_re(input logic signed [63:0] ac,
                                                input logic signed [63:0] bd,
                                                input logic conj);
    mix_re = conj ? (ac + bd) : (ac - bd);
  endfunction

  function automatic logic signed [63:0] mix_im(input logic signed [63:0] ad,
                                                input logic signed [63:0] bc,
                                                input logic conj);
    mix_im = conj ? (bc - ad) : (ad + bc);
  endfunction

  // Squared magnitude, round half up by shift bits, clamp to width bits.
  function automatic logic [63:0] pow_round_sat(input logic signed [63:0] re,
                                                input logic signed [63:0] im,
                                                input int shift, input int width);
    logic [63:0] full, rnd, lim;
    full = 64'(re * re) + 64'(im * im);
    rnd  = (full + (64'd1 << (shift - 1))) >> shift;
    lim  = (64'd1 << width) - 64'd1;
    pow_round_sat = (rnd > lim) ? lim : rnd;
  endfunction

endpackage

// File: rtl/accel_tmul_tstore.sv
module accel_tmul_tstore #(
  parameter int NPT = 1024,
  parameter int WW  = 256,
  localparam int IW = $clog2(NPT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [WW-1:0] ld_data,
  output logic          ld_last,
  input  logic [IW-1:0] rd_idx,
  output logic [WW-1:0] rd_data
);
  logic [WW-1:0] mem [NPT];
  logic [IW-1:0] wptr;
  logic          ld_fire;

  assign ld_ready = ld_en;
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_last  = ld_fire && (wptr == IW'(NPT - 1));
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr <= '0;
    else if (ld_fire) wptr <= ld_last ? '0 : wptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ld_fire) mem[wptr] <= ld_data;
  end
endmodule

// File: rtl/accel_tmul_mult.sv
module accel_tmul_mult
  import accel_tmul_pkg::*;
#(
  parameter int NPT   = 1024,
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int TW    = 16,
  localparam int IW   = $clog2(NPT),
  localparam int PRW  = DW + TW + 1,
  localparam int PDW  = LANES * 4 * PRW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic                   pass_clr,
  input  logic                   spec_valid,
  output logic                   spec_ready,
  input  logic [DW-1:0]          spec_re,
  input  logic [DW-1:0]          spec_im,
  output logic [IW-1:0]          rd_idx,
  input  logic [LANES*2*TW-1:0]  tpl_word,
  output logic                   prod_valid,
  input  logic                   prod_ready,
  output logic [PDW-1:0]         prod_data,
  output logic                   mult_idle
);
  logic [IW-1:0]  cnt;
  logic           fin;
  logic           take;
  logic [PDW-1:0] nxt;

  assign spec_ready = run_en && !fin && (!prod_valid || prod_ready);
  assign take       = spec_valid && spec_ready;
  assign rd_idx     = cnt;
  assign mult_idle  = fin && !prod_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [63:0] a, b, c, d, ac, bd, ad, bc;
    always_comb begin
      a  = 64'($signed(spec_re));
      b  = 64'($signed(spec_im));
      c  = 64'($signed(tpl_word[(2*l)*TW +: TW]));
      d  = 64'($signed(tpl_word[(2*l+1)*TW +: TW]));
      ac = a * c;
      bd = b * d;
      ad = a * d;
      bc = b * c;
    end
    assign nxt[(4*l+0)*PRW +: PRW] = PRW'(mix_re(ac, bd, 1'b0));
    assign nxt[(4*l+1)*PRW +: PRW] = PRW'(mix_im(ad, bc, 1'b0));
    assign nxt[(4*l+2)*PRW +: PRW] = PRW'(mix_re(ac, bd, 1'b1));
    assign nxt[(4*l+3)*PRW +: PRW] = PRW'(mix_im(ad, bc, 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      fin        <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      if (take) begin
        cnt <= (cnt == IW'(NPT - 1)) ? '0 : cnt + 1'b1;
        if (cnt == IW'(NPT - 1)) fin <= 1'b1;
      end
      if (take)            prod_valid <= 1'b1;
      else if (prod_ready) prod_valid <= 1'b0;
      if (pass_clr)        fin <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) prod_data <= nxt;
  end
endmodule

// File: rtl/accel_tmul_writer.sv
module accel_tmul_writer
  import accel_tmul_pkg::*;
#(
  parameter int NPT    = 1024,
  parameter int OVL    = 128,
  parameter int LANES  = 8,
  parameter int NTPL   = 43,
  parameter int PASSES = 6,
  parameter int SEGS   = 16,
  parameter int RW     = 24,
  parameter int PW     = 32,
  parameter int PSH    = 16,
  parameter int AW     = 21,
  localparam int NS    = 2 * LANES,
  localparam int SW    = $clog2(NS),
  localparam int CW    = $clog2(NPT + 1),
  localparam int PSW   = $clog2(PASSES),
  localparam int SGW   = $clog2(SEGS),
  localparam int NROWS = 2 * NTPL - 1,
  localparam int MID   = NTPL - 1,
  localparam int SEGLEN = NPT - OVL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               pass_clr,
  input  logic [PSW-1:0]     pass_idx,
  input  logic [SGW-1:0]     seg_idx,
  input  logic               ret_valid,
  output logic               ret_ready,
  input  logic [NS*2*RW-1:0] ret_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [AW-1:0]      wr_addr,
  output logic [PW-1:0]      wr_data,
  output logic               ret_idle,
  output logic               drop_evt
);
  logic [CW-1:0]      kcnt, hold_k;
  logic               busy, take, step, neg, slot_ok;
  logic [SW-1:0]      slot;
  logic [NS*2*RW-1:0] hold;
  int                 t_i, row_i, bin_i, si;
  logic signed [63:0] h_re, h_im;

  assign ret_ready = run_en && !busy && (kcnt != CW'(NPT));
  assign take      = ret_valid && ret_ready;
  assign drop_evt  = take && (int'(kcnt) < OVL);
  assign ret_idle  = (kcnt == CW'(NPT)) && !busy;

  always_comb begin
    si      = int'(slot);
    t_i     = int'(pass_idx) * LANES + si / 2;
    neg     = slot[0];
    slot_ok = (t_i < NTPL) && !(t_i == 0 && neg);
    row_i   = neg ? (MID - t_i) : (MID + t_i);
    bin_i   = int'(seg_idx) * SEGLEN + int'(hold_k) - OVL;
    h_re    = 64'($signed(hold[(2*si)*RW +: RW]));
    h_im    = 64'($signed(hold[(2*si+1)*RW +: RW]));
  end

  assign wr_valid = busy && slot_ok;
  assign wr_addr  = AW'(bin_i * NROWS + row_i);
  assign wr_data  = PW'(pow_round_sat(h_re, h_im, PSH, PW));
  assign step     = busy && (!slot_ok || wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kcnt <= '0;
      busy <= 1'b0;
      slot <= '0;
    end else begin
      if (take) begin
        kcnt <= kcnt + 1'b1;
        if (!drop_evt) begin
          busy <= 1'b1;
          slot <= '0;
        end
      end else if (step) begin
        if (slot == SW'(NS - 1)) busy <= 1'b0;
        else                     slot <= slot + 1'b1;
      end
      if (pass_clr) kcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !drop_evt) begin
      hold   <= ret_data;
      hold_k <= kcnt;
    end
  end
endmodule

// File: rtl/accel_tmul_pdet.sv
module accel_tmul_pdet
  import accel_tmul_pkg::*;
#(
  parameter int NPT    = 1024,
  parameter int OVL    = 128,
  parameter int NTPL   = 43,
  parameter int PASSES = 6,
  parameter int SEGS   = 16,
  parameter int DW     = 16,
  parameter int TW     = 16,
  parameter int RW     = 24,
  parameter int PW     = 32,
  parameter int PSH    = 16,
  parameter int AW     = 21,
  localparam int LANES = (NTPL + PASSES - 1) / PASSES,
  localparam int PRW   = DW + TW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tpl_valid,
  output logic                   tpl_ready,
  input  logic [LANES*2*TW-1:0]  tpl_data,
  input  logic                   spec_valid,
  output logic                   spec_ready,
  input  logic [DW-1:0]          spec_re,
  input  logic [DW-1:0]          spec_im,
  output logic                   prod_valid,
  input  logic                   prod_ready,
  output logic [LANES*4*PRW-1:0] prod_data,
  input  logic                   ret_valid,
  output logic                   ret_ready,
  input  logic [LANES*4*RW-1:0]  ret_data,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [AW-1:0]          wr_addr,
  output logic [PW-1:0]          wr_data,
  output logic                   done
);
  localparam int IW  = $clog2(NPT);
  localparam int PSW = $clog2(PASSES);
  localparam int SGW = $clog2(SEGS);

  tmul_phase_e           phase;
  logic [PSW-1:0]        pass_idx;
  logic [SGW-1:0]        seg_idx;
  logic                  ld_last, run_en, mult_idle, ret_idle, pass_end, last_pass;
  logic                  ov_drop;
  logic [IW-1:0]         rd_idx;
  logic [LANES*2*TW-1:0] tpl_word;

  assign run_en    = (phase == PH_RUN);
  assign pass_end  = run_en && mult_idle && ret_idle;
  assign last_pass = (pass_idx == PSW'(PASSES - 1));

  accel_tmul_tstore #(.NPT(NPT), .WW(LANES*2*TW)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_en(phase == PH_LOAD), .ld_valid(tpl_valid),
    .ld_ready(tpl_ready), .ld_data(tpl_data), .ld_last(ld_last),
    .rd_idx(rd_idx), .rd_data(tpl_word));

  accel_tmul_mult #(.NPT(NPT), .LANES(LANES), .DW(DW), .TW(TW)) u_mult (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pass_clr(pass_end),
    .spec_valid(spec_valid), .spec_ready(spec_ready), .spec_re(spec_re), .spec_im(spec_im),
    .rd_idx(rd_idx), .tpl_word(tpl_word), .prod_valid(prod_valid),
    .prod_ready(prod_ready), .prod_data(prod_data), .mult_idle(mult_idle));

  accel_tmul_writer #(.NPT(NPT), .OVL(OVL), .LANES(LANES), .NTPL(NTPL), .PASSES(PASSES),
                      .SEGS(SEGS), .RW(RW), .PW(PW), .PSH(PSH), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pass_clr(pass_end),
    .pass_idx(pass_idx), .seg_idx(seg_idx), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_data(ret_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .ret_idle(ret_idle), .drop_evt(ov_drop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      pass_idx <= '0;
      seg_idx  <= '0;
      done     <= 1'b0;
    end else begin
      done <= pass_end && last_pass;
      if (phase == PH_LOAD && ld_last) phase <= PH_RUN;
      if (pass_end) begin
        phase <= PH_LOAD;
        if (last_pass) begin
          pass_idx <= '0;
          seg_idx  <= (seg_idx == SGW'(SEGS - 1)) ? '0 : seg_idx + 1'b1;
        end else begin
          pass_idx <= pass_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/accel_tmul_pdet_chk.sv
module accel_tmul_pdet_chk #(
  parameter int PDW  = 8,
  parameter int AW   = 8,
  parameter int PW   = 8,
  parameter int AMAX = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tpl_ready,
  input logic           spec_ready,
  input logic           prod_valid,
  input logic           prod_ready,
  input logic [PDW-1:0] prod_data,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [AW-1:0]  wr_addr,
  input logic [PW-1:0]  wr_data,
  input logic           done,
  input logic           ov_drop
);
  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tpl_ready && spec_ready));

  p_prod_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid && !prod_ready |=> prod_valid && $stable(prod_data));

  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_drop |=> !wr_valid);

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (int'(wr_addr) < AMAX));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
endmodule

bind accel_tmul_pdet accel_tmul_pdet_chk #(
  .PDW(LANES*4*PRW), .AW(AW), .PW(PW), .AMAX(SEGS*(NPT-OVL)*(2*NTPL-1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .tpl_ready(tpl_ready), .spec_ready(spec_ready),
  .prod_valid(prod_valid), .prod_ready(prod_ready), .prod_data(prod_data),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .ov_drop(ov_drop));

// File: tb/accel_tmul_pdet_bench.sv
module accel_tmul_pdet_bench;
  localparam int NPT = 8, OVL = 2, NTPL = 3, PASSES = 2, SEGS = 2;
  localparam int DW = 8, TW = 8, RW = 8, PW = 8, PSH = 4, AW = 8;
  localparam int LANES = 2, PRW = DW + TW + 1, NS = 2 * LANES;
  localparam int NROWS = 2 * NTPL - 1, MID = NTPL - 1, NRUN = 3;

  logic clk = 0, rst_n = 0;
  logic tpl_valid = 0, spec_valid = 0, ret_valid = 0, prod_ready = 0, wr_ready = 0;
  logic tpl_ready, spec_ready, prod_valid, ret_ready, wr_valid, done;
  logic [LANES*2*TW-1:0]  tpl_data = '0;
  logic [DW-1:0]          spec_re = '0, spec_im = '0;
  logic [LANES*4*PRW-1:0] prod_data;
  logic [LANES*4*RW-1:0]  ret_data = '0;
  logic [AW-1:0]          wr_addr;
  logic [PW-1:0]          wr_data;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, wr_seen = 0;
  int pi = 0, pp = 0, ps = 0;
  int exp_addr[$], exp_data[$];
  bit finished = 0, live = 0;
  bit stall_prev = 0;
  int prev_addr, prev_data;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  accel_tmul_pdet #(.NPT(NPT), .OVL(OVL), .NTPL(NTPL), .PASSES(PASSES), .SEGS(SEGS),
    .DW(DW), .TW(TW), .RW(RW), .PW(PW), .PSH(PSH), .AW(AW)) u_accel_tmul_pdet (.*);

  function automatic int v8(input int x);
    return ((x % 256) + 256) % 256 - 128;
  endfunction
  function automatic int s_re(int s, int i); return v8(s*97 + i*13 + 1); endfunction
  function automatic int s_im(int s, int i); return v8(s*53 + i*7 + 5); endfunction
  function automatic int t_re(int p, int i, int l); return v8(p*17 + i*23 + l*61 + 3); endfunction
  function automatic int t_im(int p, int i, int l); return v8(p*31 + i*19 + l*43 + 120); endfunction
  function automatic int r_re(int s, int p, int k, int j);
    if (k == OVL) return -128;
    if (k == OVL + 1) return j + 1;
    if (k == OVL + 2) return 2;
    return v8(s*71 + p*13 + k*29 + j*47 + 2);
  endfunction
  function automatic int r_im(int s, int p, int k, int j);
    if (k == OVL) return -128;
    if (k == OVL + 1) return j;
    if (k == OVL + 2) return 2;
    return v8(s*37 + p*59 + k*11 + j*83 + 7);
  endfunction
  function automatic int pwr(int re, int im);
    int q;
    q = (re*re + im*im + (1 << (PSH-1))) / (1 << PSH);
    return (q > (1 << PW) - 1) ? (1 << PW) - 1 : q;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push_tpl(input int p, input int i);
    for (int l = 0; l < LANES; l++) begin
      tpl_data[(2*l)*TW +: TW]   = TW'(t_re(p, i, l));
      tpl_data[(2*l+1)*TW +: TW] = TW'(t_im(p, i, l));
    end
    tpl_valid = 1;
    #1;
    while (!tpl_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tpl_valid = 0;
  endtask

  task automatic push_spec(input int s, input int i);
    spec_re = DW'(s_re(s, i));
    spec_im = DW'(s_im(s, i));
    spec_valid = 1;
    #1;
    while (!spec_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    spec_valid = 0;
  endtask

  task automatic push_ret(input int s, input int p, input int k);
    for (int j = 0; j < NS; j++) begin
      ret_data[(2*j)*RW +: RW]   = RW'(r_re(s, p, k, j));
      ret_data[(2*j+1)*RW +: RW] = RW'(r_im(s, p, k, j));
    end
    ret_valid = 1;
    #1;
    while (!ret_ready) begin @(negedge clk); #1; end
    // R6 R8 R9: expectations for this word, in slot order, overlap samples excluded
    if (k >= OVL) begin
      for (int j = 0; j < NS; j++) begin
        int t, row;
        t = p * LANES + j / 2;
        if (t < NTPL && !(t == 0 && (j % 2) == 1)) begin
          row = (j % 2 == 1) ? MID - t : MID + t;
          exp_addr.push_back(((s % SEGS) * (NPT - OVL) + k - OVL) * NROWS + row);
          exp_data.push_back(pwr(r_re(s, p, k, j), r_im(s, p, k, j)));
        end
      end
    end
    @(negedge clk);
    ret_valid = 0;
  endtask

  // product sink: throttled, every product compared against bench arithmetic
  always @(negedge clk) begin
    prod_ready = live && ((cyc % 4) != 2);
    #1;
    if (prod_valid && prod_ready) begin
      int a, b, c, d;
      a = s_re(ps, pi); b = s_im(ps, pi);
      for (int l = 0; l < LANES; l++) begin
        c = t_re(pp, pi, l); d = t_im(pp, pi, l);
        chk(int'($signed(prod_data[(4*l+0)*PRW +: PRW])) == a*c - b*d, "R3 pos real",
            int'($signed(prod_data[(4*l+0)*PRW +: PRW])), a*c - b*d);
        chk(int'($signed(prod_data[(4*l+1)*PRW +: PRW])) == a*d + b*c, "R3 pos imag",
            int'($signed(prod_data[(4*l+1)*PRW +: PRW])), a*d + b*c);
        chk(int'($signed(prod_data[(4*l+2)*PRW +: PRW])) == a*c + b*d, "R4 conj real",
            int'($signed(prod_data[(4*l+2)*PRW +: PRW])), a*c + b*d);
        chk(int'($signed(prod_data[(4*l+3)*PRW +: PRW])) == b*c - a*d, "R4 conj imag",
            int'($signed(prod_data[(4*l+3)*PRW +: PRW])), b*c - a*d);
      end
      pi++;
      if (pi == NPT) begin pi = 0; pp++; end
      if (pp == PASSES) begin pp = 0; ps++; end
    end
  end

  // plane write sink
  always @(negedge clk) begin
    wr_ready = live && ((cyc % 3) != 1);
    #1;
    if (stall_prev) begin
      chk(wr_valid && int'(wr_addr) == prev_addr, "R11 held address", int'(wr_addr), prev_addr);
      chk(int'(wr_data) == prev_data, "R11 held data", int'(wr_data), prev_data);
    end
    stall_prev = wr_valid && !wr_ready;
    prev_addr  = int'(wr_addr);
    prev_data  = int'(wr_data);
    if (wr_valid && wr_ready) begin
      wr_seen++;
      if (exp_addr.size() == 0) chk(0, "R6 unexpected write", int'(wr_addr), -1);
      else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(int'(wr_addr) == ea, "R8 R9 address", int'(wr_addr), ea);
        chk(int'(wr_data) == ed, "R7 power", int'(wr_data), ed);
      end
    end
  end

  // R10: done only after all writes of the segment are out
  always @(negedge clk) begin
    #1;
    if (done) begin
      done_cnt++;
      chk(exp_addr.size() == 0, "R10 done before writes drained", exp_addr.size(), 0);
      chk(tpl_ready, "R10 back in load after done", tpl_ready, 1);
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(tpl_ready == 1, "R1 tpl_ready", tpl_ready, 1);
    chk(spec_ready == 0, "R1 spec_ready", spec_ready, 0);
    chk(ret_ready == 0, "R1 ret_ready", ret_ready, 0);
    chk(prod_valid == 0, "R1 prod_valid", prod_valid, 0);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    chk(done == 0, "R1 done", done, 0);
    @(negedge clk);
    live = 1;
    for (int s = 0; s < NRUN; s++) begin
      for (int p = 0; p < PASSES; p++) begin
        for (int i = 0; i < NPT; i++) push_tpl(p, i);
        chk(tpl_ready == 0, "R2 load closed after NPT words", tpl_ready, 0);
        fork
          begin
            for (int i = 0; i < NPT; i++) push_spec(s, i);
            chk(spec_ready == 0, "R5 spectrum closed after NPT samples", spec_ready, 0);
          end
          begin
            for (int k = 0; k < NPT; k++) push_ret(s, p, k);
          end
        join
      end
      while (done_cnt < s + 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == NRUN, "R10 done pulse count", done_cnt, NRUN);
    chk(wr_seen == NRUN * (NPT - OVL) * NROWS, "R6 total writes", wr_seen,
        NRUN * (NPT - OVL) * NROWS);
    chk(pi == 0 && pp == 0 && ps == NRUN, "R5 product count", ps, NRUN);
    summary();
  end
endmodule